// File: doc/BRIEF.md
# Partitioned 8x16 Multiply Unit

This block is a four-lane SIMD multiplier. Each lane multiplies an unsigned 8-bit factor by a signed 16-bit factor. It keeps the middle sixteen bits of the product, rounds them using the bit just below, and packs the four 16-bit results into one 64-bit word. A 3-bit mode input sets where each lane's factors come from. The 8-bit factor can be one byte of a 32-bit operand, or the upper or lower byte of a 16-bit lane. The 16-bit factor can be a per-lane value or one scalar shared by all lanes.

Operands enter through a valid/ready input channel, and results leave through a valid/ready output channel. A single output register sits between the two channels. An operand set is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. A result stays in the output register, unchanged, until `out_ready` takes it. No result is ever dropped or duplicated.

Top module: `pmul8x16`

## Requirements
- R1: For each lane, the 8-bit factor (unsigned, 0..255) is multiplied by the 16-bit factor (two's complement) to form an exact signed product. The lane result is bits [23:8] of that product.
- R2: One is added to the lane result when product bit 7 is 1. The addition wraps modulo 2^16.
- R3: Mode 0 is the per-lane mode. Lane k multiplies byte k of `in_a[31:0]` (bits [8k+7:8k]) by `in_b[16k+15:16k]`. Lane k's result goes to `out_data[16k+15:16k]`; the same result position applies in every mode.
- R4: Mode 1 is the scalar-upper mode. Lane k multiplies byte k of `in_a[31:0]` by the single value `in_b[31:16]`.
- R5: Mode 2 is the scalar-lower mode. Lane k multiplies byte k of `in_a[31:0]` by the single value `in_b[15:0]`.
- R6: Mode 3 is the high-byte mode. Lane k multiplies `in_a[16k+15:16k+8]` by `in_b[16k+15:16k]`.
- R7: Mode 4 is the low-byte mode. Lane k multiplies `in_a[16k+7:16k]` by `in_b[16k+15:16k]`.
- R8: Mode codes 5, 6 and 7 behave exactly like mode 0.
- R9: Synchronous active-high `rst` clears `out_valid`. An operand set accepted on a clock edge makes `out_valid` high after that edge, and its result is on `out_data` from then on.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R11: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. Results leave in the order their operands were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be accepted |
| in_mode | input | 3 | Operand-selection mode |
| in_a | input | 64 | Source of the unsigned 8-bit factors |
| in_b | input | 64 | Source of the signed 16-bit factors |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 64 | Four packed 16-bit lane results |

## Verification
A wrong factor selection or wrong rounding shows up as a mismatched lane on `out_data` in the first cycle the result is valid. The scoreboard pinpoints the failing lane because each mode is tested with distinct random bytes. A faulty hold register shows up as a changed `out_data` during a stall. It can also show up as a lost or repeated result, which puts every later comparison out of order. A wrong ready equation is caught at the same negedge, by direct comparison with the state of `out_valid` and `out_ready`.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int unsigned U_W   = 8;
  localparam int unsigned S_W   = 16;
  localparam int unsigned LANES = 4;

  typedef enum logic [2:0] {
    MODE_LANE    = 3'd0,
    MODE_SCAL_HI = 3'd1,
    MODE_SCAL_LO = 3'd2,
    MODE_BYTE_HI = 3'd3,
    MODE_BYTE_LO = 3'd4
  } mode_e;
endpackage

// File: rtl/pmul_opsel.sv
module pmul_opsel #(
  parameter int unsigned U_W   = 8,
  parameter int unsigned S_W   = 16,
  parameter int unsigned LANES = 4,
  localparam int unsigned OP_W = LANES * S_W
) (
  input  logic [2:0]                  mode,
  input  logic [OP_W-1:0]             opa,
  input  logic [OP_W-1:0]             opb,
  output logic [LANES-1:0][U_W-1:0]   fac_u,
  output logic [LANES-1:0][S_W-1:0]   fac_s
);
  import pmul_pkg::*;

  logic [S_W-1:0] scal_hi, scal_lo;
  assign scal_hi = opb[2*S_W-1:S_W];
  assign scal_lo = opb[S_W-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [U_W-1:0] pk_byte, hi_byte, lo_byte;
    logic [S_W-1:0] own_half;
    assign pk_byte  = opa[k*U_W +: U_W];
    assign hi_byte  = opa[k*S_W + U_W +: U_W];
    assign lo_byte  = opa[k*S_W +: U_W];
    assign own_half = opb[k*S_W +: S_W];

    always_comb begin
      case (mode)
        MODE_SCAL_HI: begin fac_u[k] = pk_byte; fac_s[k] = scal_hi;  end
        MODE_SCAL_LO: begin fac_u[k] = pk_byte; fac_s[k] = scal_lo;  end
        MODE_BYTE_HI: begin fac_u[k] = hi_byte; fac_s[k] = own_half; end
        MODE_BYTE_LO: begin fac_u[k] = lo_byte; fac_s[k] = own_half; end
        default:      begin fac_u[k] = pk_byte; fac_s[k] = own_half; end
      endcase
    end
  end
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int unsigned U_W = 8,
  parameter int unsigned S_W = 16,
  localparam int unsigned P_W = U_W + S_W + 1
) (
  input  logic [U_W-1:0] fac_u,
  input  logic [S_W-1:0] fac_s,
  output logic [S_W-1:0] res
);
  logic signed [P_W-1:0] prod;
  assign prod = $signed({1'b0, fac_u}) * $signed(fac_s);
  assign res  = prod[U_W+S_W-1:U_W] + {{(S_W-1){1'b0}}, prod[U_W-1]};
endmodule

// File: rtl/pmul8x16.sv
module pmul8x16 #(
  parameter int unsigned U_W   = 8,
  parameter int unsigned S_W   = 16,
  parameter int unsigned LANES = 4,
  localparam int unsigned OP_W = LANES * S_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_mode,
  input  logic [OP_W-1:0] in_a,
  input  logic [OP_W-1:0] in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OP_W-1:0] out_data
);
  logic [LANES-1:0][U_W-1:0] fac_u;
  logic [LANES-1:0][S_W-1:0] fac_s;
  logic [LANES-1:0][S_W-1:0] lane_res;
  logic                      take;

  pmul_opsel #(.U_W(U_W), .S_W(S_W), .LANES(LANES)) u_sel (
    .mode(in_mode), .opa(in_a), .opb(in_b), .fac_u(fac_u), .fac_s(fac_s)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_mul
    pmul_lane #(.U_W(U_W), .S_W(S_W)) u_lane (
      .fac_u(fac_u[k]), .fac_s(fac_s[k]), .res(lane_res[k])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_data <= lane_res;
  end
endmodule

// File: rtl/pmul8x16_chk.sv
module pmul8x16_chk #(
  parameter int unsigned OP_W = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OP_W-1:0] in_b,
  input logic            out_valid,
  input logic            out_ready,
  input logic [OP_W-1:0] out_data
);
  // R9: reset empties the output register
  assert_reset_clear_R9: assert property (@(posedge clk) rst |=> !out_valid);

  // R9: accepted operands produce a valid result after the edge
  assert_valid_after_take_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R10: stalled result is held
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11: an empty register always accepts
  assert_ready_when_empty_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R1: zero signed factors give a zero result in every mode
  assert_zero_factor_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_b == '0) |=> (out_data == '0));
endmodule

bind pmul8x16 pmul8x16_chk #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/pmul8x16_tb.sv
module pmul8x16_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmul8x16 u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // R1 R2: one lane from first principles
  function automatic logic [15:0] lane_ref(input logic [7:0] u, input logic [15:0] s);
    int p;
    logic [31:0] pv;
    p  = int'(u) * int'($signed(s));
    pv = p;
    return pv[23:8] + {15'd0, pv[7]};
  endfunction

  // R3..R8: factor selection per mode
  function automatic logic [63:0] model(input logic [2:0] m, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [7:0]  u;
      logic [15:0] s;
      case (m)
        3'd1: begin u = a[8*k +: 8];      s = b[31:16];      end
        3'd2: begin u = a[8*k +: 8];      s = b[15:0];       end
        3'd3: begin u = a[16*k+8 +: 8];   s = b[16*k +: 16]; end
        3'd4: begin u = a[16*k +: 8];     s = b[16*k +: 16]; end
        default: begin u = a[8*k +: 8];   s = b[16*k +: 16]; end
      endcase
      r[16*k +: 16] = lane_ref(u, s);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: offers at negedge, accepted if in_ready seen before the edge
  task automatic send(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b,
                      input string req);
    bit acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1; in_mode = m; in_a = a; in_b = b;
      acc = in_ready;
      @(posedge clk);
    end
    exp_q.push_back(model(m, a, b));
    @(negedge clk);
    in_valid = 1'b0;
    // R9: result visible right after the accepting edge
    check(out_valid === 1'b1, {"R9 valid after accept ", req}, {63'd0, out_valid}, 64'd1);
  endtask

  // out_ready pattern, changed shortly after posedge
  always @(posedge clk) begin
    #2;
    out_ready <= stall_mode ? ($urandom_range(0, 2) == 0) : 1'b1;
  end

  // monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [63:0] prev_data = '0;
  always @(negedge clk) begin
    if (!rst) begin
      check(in_ready === (!out_valid || out_ready), "R11 ready rule",
            {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
      if (prev_stall)
        check(out_valid === 1'b1 && out_data === prev_data, "R10 held during stall",
              out_data, prev_data);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R11 unexpected result", out_data, 64'd0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check(out_data === e, "R3-model result", out_data, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check(out_valid === 1'b0, "R9 reset clears valid", {63'd0, out_valid}, 64'd0);
    check(in_ready === 1'b1, "R11 ready after reset", {63'd0, in_ready}, 64'd1);

    // R1 R2 R3: extremes in the per-lane mode
    send(3'd0, 64'h0000_0000_FFFF_FFFF, 64'h8000_8000_8000_8000, "R1 extremes");
    send(3'd0, 64'h0000_0000_FF01_80FF, 64'h7FFF_0080_FFFF_7FFF, "R2 rounding");
    // R4 R5: scalar modes with extreme scalar
    send(3'd1, 64'h0000_0000_FF80_01FF, 64'h0000_0000_8000_1234, "R4 scalar hi");
    send(3'd2, 64'h0000_0000_FF80_01FF, 64'h0000_0000_1234_8000, "R5 scalar lo");
    // R6 R7: byte-select modes
    send(3'd3, 64'hFF11_0122_8033_7F44, 64'h8000_7FFF_0101_FF00, "R6 byte hi");
    send(3'd4, 64'h11FF_2201_3380_447F, 64'h8000_7FFF_0101_FF00, "R7 byte lo");
    // R8: unused codes act like mode 0
    for (int c = 5; c < 8; c++)
      send(3'(c), 64'hDEAD_BEEF_A5C3_0FF0, 64'h1357_9BDF_8642_ECA8, "R8 unused code");

    // random, all modes, no back-pressure
    for (int i = 0; i < 200; i++)
      send(3'($urandom_range(0, 7)), {$urandom, $urandom}, {$urandom, $urandom}, "R3 random");

    // R10 R11: random back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 300; i++)
      send(3'($urandom_range(0, 7)), {$urandom, $urandom}, {$urandom, $urandom}, "R10 random");
    stall_mode = 1'b0;

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R11 all results delivered", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule